// File: doc/BRIEF.md
# Accumulator Memory-Reference Execute Unit

This block runs programs for a 12-bit, word-addressed accumulator machine, one instruction at a time, over several clock cycles. It fetches a one-word instruction from a synchronous single-port memory. It forms an operand address from a 7-bit offset and a page-select bit, and it can follow one level of indirection through memory. It then carries out one of six memory-reference operations: logical AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, jump and jump-to-subroutine.

There is no load operation. Software loads a value by clearing the accumulator and then adding the memory word. A store writes the accumulator and clears it in the same step. A link bit sits beside the accumulator and flips on every carry out of an add. The two remaining opcodes are treated as no-ops, with one exception: a clear-accumulator bit in the operate group is honoured.

The program counter, the accumulator and the link are brought out as registered outputs. The memory returns read data one clock after it receives an address.

Top module: `acc_mr_exec`

## Requirements
- R1: While `rst` is high, the PC is set to octal 0200, and the accumulator and the link are set to 0.
- R2: An instruction word is split into fields as follows: bits [11:9] hold the opcode, bit [8] selects indirect addressing, bit [7] selects the page, and bits [6:0] hold the offset. The opcode values are 0=AND, 1=add, 2=increment-and-skip, 3=deposit-and-clear, 4=subroutine jump, 5=jump, 6=I/O and 7=operate.
- R3: When bit [7] is 1, the direct address is the top 5 bits of the instruction's own address followed by the offset. When bit [7] is 0, the direct address is 5 zero bits followed by the offset.
- R4: For opcodes 0 to 5 with bit [8] set, the word stored at the direct address becomes the final address. Only one level of indirection is applied.
- R5: AND replaces the accumulator with the accumulator ANDed with the operand. The link does not change.
- R6: Add sets the accumulator to (accumulator + operand) mod 4096, and it inverts the link when the sum carries out of bit 11.
- R7: Deposit-and-clear writes the accumulator to the final address and then sets the accumulator to 0. The link does not change.
- R8: Increment-and-skip writes (operand + 1) mod 4096 back to the same address. If that result is 0, the PC advances by 2 instead of 1. The accumulator and the link do not change.
- R9: Jump loads the final address into the PC.
- R10: Subroutine jump writes the instruction's address + 1 to the final address and continues execution at the final address + 1.
- R11: Opcode 6 changes nothing except the PC. Opcode 7 also changes nothing else, except that when bit [7] is set it clears the accumulator. The link does not change in either case.
- R12: Every PC update wraps modulo 4096.
- R13: An instruction takes the following number of clock cycles: 2 for a direct jump, opcode 6 or opcode 7; 3 for deposit-and-clear or subroutine jump; 4 for AND or add; and 5 for increment-and-skip. Indirect addressing adds 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 12 | Memory read data, valid one cycle after its address |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc_o | output | 12 | Program counter |
| acc_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |

## Verification
The assertions check the following properties on every cycle:
- the reset values;
- that a deposit clears the accumulator and leaves the link unchanged;
- that increment-and-skip never disturbs the accumulator or the link;
- the return-target arithmetic of the subroutine jump;
- the regular PC step;
- the fact that memory is written only in its two write states.

The remaining behaviours depend on program context and are shown only by the bench's scenarios. These are:
- page-relative and indirect address formation;
- the carry into the link;
- the skip taken on a zero result;
- PC wrap-around;
- the per-opcode cycle counts.

The bench compares the PC, the accumulator and the link against its own instruction model at every instruction boundary, under both directed and random programs.

// File: rtl/acc_mr_pkg.sv
package acc_mr_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_TAD = 3'd1,
    OP_ISZ = 3'd2,
    OP_DCA = 3'd3,
    OP_JMS = 3'd4,
    OP_JMP = 3'd5,
    OP_IOT = 3'd6,
    OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_IND,
    ST_INDRD,
    ST_EXEC,
    ST_READ,
    ST_WBACK
  } state_e;

  function automatic logic is_memref(opcode_e op);
    return (op != OP_IOT) && (op != OP_OPR);
  endfunction

  function automatic logic needs_read(opcode_e op);
    return (op == OP_AND) || (op == OP_TAD) || (op == OP_ISZ);
  endfunction

endpackage

// File: rtl/xu_field_decode.sv
module xu_field_decode
  import acc_mr_pkg::*;
#(
  parameter int DW   = 12,
  parameter int OFFW = 7
) (
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] pc,
  output opcode_e       op,
  output logic          ind,
  output logic [DW-1:0] ea
);
  localparam int PAGEW = DW - OFFW;

  logic page;

  // R2: opcode in the top three bits, then the indirect flag, then the page flag
  assign op   = opcode_e'(word[DW-1 -: 3]);
  assign ind  = word[DW-4];
  assign page = word[DW-5];

  // R3: the page flag picks the current page or page zero
  assign ea = page ? {pc[DW-1 -: PAGEW], word[OFFW-1:0]}
                   : {{PAGEW{1'b0}}, word[OFFW-1:0]};
endmodule

// File: rtl/xu_alu.sv
module xu_alu
  import acc_mr_pkg::*;
#(
  parameter int DW = 12
) (
  input  opcode_e       op,
  input  logic [DW-1:0] acc,
  input  logic          link,
  input  logic [DW-1:0] mdata,
  output logic [DW-1:0] acc_n,
  output logic          link_n,
  output logic [DW-1:0] inc
);
  logic [DW:0] sum;

  assign sum = {1'b0, acc} + {1'b0, mdata};
  assign inc = mdata + 1'b1;

  always_comb begin
    acc_n  = acc;
    link_n = link;
    unique case (op)
      OP_AND: acc_n = acc & mdata;
      OP_TAD: begin
        acc_n  = sum[DW-1:0];
        link_n = link ^ sum[DW];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xu_seq.sv
module xu_seq
  import acc_mr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op_dec,
  input  logic    ind_dec,
  input  opcode_e op_ir,
  output state_e  state
);
  state_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (!is_memref(op_dec))      nxt = ST_FETCH;
        else if (ind_dec)            nxt = ST_IND;
        else if (op_dec == OP_JMP)   nxt = ST_FETCH;
        else                         nxt = ST_EXEC;
      end
      ST_IND:    nxt = ST_INDRD;
      ST_INDRD:  nxt = (op_ir == OP_JMP) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   nxt = needs_read(op_ir) ? ST_READ : ST_FETCH;
      ST_READ:   nxt = (op_ir == OP_ISZ) ? ST_WBACK : ST_FETCH;
      ST_WBACK:  nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  // R13: a fetch is always followed by its decode cycle
  a_r13_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_DECODE);

  // R13: the write-back step occurs only after an increment read
  a_r13_wback_after_read: assert property (@(posedge clk) disable iff (rst)
    state == ST_WBACK |-> $past(state) == ST_READ);
endmodule

// File: rtl/acc_mr_exec.sv
module acc_mr_exec
  import acc_mr_pkg::*;
#(
  parameter int          DW       = 12,
  parameter int          OFFW     = 7,
  parameter logic [11:0] RESET_PC = 12'o0200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          link_o
);
  localparam int CLRBIT = DW - 5;

  state_e        state;
  opcode_e       op_dec, op_ir;
  logic          ind_dec;
  logic [DW-1:0] ea_dec, ea, mdr;
  logic [DW-1:0] pc, acc;
  logic          link;
  logic [DW-1:0] alu_acc, alu_inc;
  logic          alu_link;

  xu_field_decode #(.DW(DW), .OFFW(OFFW)) u_dec (
    .word (mem_rdata),
    .pc   (pc),
    .op   (op_dec),
    .ind  (ind_dec),
    .ea   (ea_dec)
  );

  xu_alu #(.DW(DW)) u_alu (
    .op     (op_ir),
    .acc    (acc),
    .link   (link),
    .mdata  (mem_rdata),
    .acc_n  (alu_acc),
    .link_n (alu_link),
    .inc    (alu_inc)
  );

  xu_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .op_dec  (op_dec),
    .ind_dec (ind_dec),
    .op_ir   (op_ir),
    .state   (state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= DW'(RESET_PC);
      acc   <= '0;
      link  <= 1'b0;
      ea    <= '0;
      mdr   <= '0;
      op_ir <= OP_AND;
    end else begin
      unique case (state)
        ST_DECODE: begin
          op_ir <= op_dec;
          ea    <= ea_dec;
          if (op_dec == OP_JMP && !ind_dec) pc <= ea_dec;  // R9
          else                              pc <= pc + 1'b1;  // R12
          if (op_dec == OP_OPR && mem_rdata[CLRBIT]) acc <= '0;  // R11
        end
        ST_INDRD: begin
          ea <= mem_rdata;  // R4
          if (op_ir == OP_JMP) pc <= mem_rdata;
        end
        ST_EXEC: begin
          if (op_ir == OP_DCA) acc <= '0;  // R7
          if (op_ir == OP_JMS) pc  <= ea + 1'b1;  // R10
        end
        ST_READ: begin
          if (op_ir == OP_ISZ) mdr <= alu_inc;
          else begin
            acc  <= alu_acc;  // R5, R6
            link <= alu_link;
          end
        end
        ST_WBACK: begin
          if (mdr == '0) pc <= pc + 1'b1;  // R8 skip
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = (state == ST_FETCH) ? pc : ea;
  assign mem_we    = (state == ST_WBACK) ||
                     (state == ST_EXEC && (op_ir == OP_DCA || op_ir == OP_JMS));
  assign mem_wdata = (state == ST_WBACK) ? mdr : ((op_ir == OP_JMS) ? pc : acc);

  assign pc_o   = pc;
  assign acc_o  = acc;
  assign link_o = link;

  // R1: reset values
  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (pc_o == DW'(RESET_PC) && acc_o == '0 && !link_o));

  // R7: deposit writes the accumulator, then clears it, link untouched
  a_r7_dca_clears: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op_ir == OP_DCA) |=> (acc_o == '0 && $stable(link_o)));

  // R8: increment-and-skip leaves accumulator and link alone
  a_r8_isz_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_READ || state == ST_WBACK) && op_ir == OP_ISZ)
      |=> ($stable(acc_o) && $stable(link_o)));

  // R10: subroutine jump resumes one past the written address
  a_r10_jms_target: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op_ir == OP_JMS) |=> pc_o == $past(mem_addr) + 1'b1);

  // R12: a non-jump decode steps the PC by one, wrapping
  a_r12_pc_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !(op_dec == OP_JMP && !ind_dec))
      |=> pc_o == $past(pc_o) + 1'b1);

  // R13: no memory write outside the two write steps
  a_r13_write_states: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_EXEC || state == ST_WBACK));
endmodule

// File: tb/test_acc_mr_exec.sv
module test_acc_mr_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_rdata, mem_addr, mem_wdata, pc_o, acc_o;
  logic        mem_we, link_o;

  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0, ld_data = '0;
  logic [11:0] mem     [4096];
  logic [11:0] ref_mem [4096];
  logic [11:0] r_pc, r_acc;
  logic        r_link;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_mr_exec i_acc_mr_exec (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_o(pc_o), .acc_o(acc_o),
    .link_o(link_o)
  );

  // bench memory: one-cycle synchronous read
  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string what, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%o exp=%o", what, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    ref_mem[a] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // reference model of one instruction; returns its cycle count (R13)
  task automatic iss_step(output int cyc, output string tag);
    logic [11:0] w, ea, npc, m, t;
    logic [12:0] s;
    logic [2:0]  op;
    w   = ref_mem[r_pc];
    op  = w[11:9];                       // R2 field positions
    ea  = w[7] ? {r_pc[11:7], w[6:0]} : {5'b0, w[6:0]};  // R3
    npc = r_pc + 12'd1;                  // R12
    cyc = 2;
    if (op < 3'd6 && w[8]) begin ea = ref_mem[ea]; cyc += 2; end  // R4
    m = ref_mem[ea];
    case (op)
      3'd0: begin r_acc = r_acc & m; cyc += 2; tag = "R5"; end
      3'd1: begin s = {1'b0, r_acc} + {1'b0, m}; r_acc = s[11:0];
                  r_link ^= s[12]; cyc += 2; tag = "R6"; end
      3'd2: begin t = m + 12'd1; ref_mem[ea] = t;
                  if (t == 12'd0) npc = npc + 12'd1; cyc += 3; tag = "R8"; end
      3'd3: begin ref_mem[ea] = r_acc; r_acc = '0; cyc += 1; tag = "R7"; end
      3'd4: begin ref_mem[ea] = npc; npc = ea + 12'd1; cyc += 1; tag = "R10"; end
      3'd5: begin npc = ea; tag = "R9"; end
      3'd6: tag = "R11";
      default: begin if (w[7]) r_acc = '0; tag = "R11"; end
    endcase
    r_pc = npc;
  endtask

  task automatic run(input int n, input string name);
    int cyc;
    string tag;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    r_pc = 12'o0200; r_acc = '0; r_link = 1'b0;
    // R1: reset state visible in the first fetch cycle
    chk({name, " R1 pc"}, pc_o, 12'o0200);
    chk({name, " R1 acc"}, acc_o, 12'o0);
    chk({name, " R1 link"}, {11'b0, link_o}, 12'o0);
    for (int i = 0; i < n; i++) begin
      iss_step(cyc, tag);
      repeat (cyc) @(negedge clk);
      chk($sformatf("%s step%0d %s pc(R3 R4 R12 R13)", name, i, tag), pc_o, r_pc);
      chk($sformatf("%s step%0d %s acc", name, i, tag), acc_o, r_acc);
      chk($sformatf("%s step%0d %s link", name, i, tag), {11'b0, link_o}, {11'b0, r_link});
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    begin
      int diff = 0;
      for (int a = 0; a < 4096; a++) if (mem[a] !== ref_mem[a]) diff++;
      chk({name, " memory image (R7 R8 R10)"}, 12'(diff), 12'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20231));
    for (int a = 0; a < 4096; a++) load(12'(a), 12'o0);

    // directed: carry into link, AND, deposit, zero skip, indirect, page, JMS
    load(12'o0010, 12'o7777); load(12'o0011, 12'o0001);
    load(12'o0012, 12'o7777); load(12'o0013, 12'o0300);
    load(12'o0014, 12'o5252); load(12'o0300, 12'o0042);
    load(12'o0260, 12'o1234);
    load(12'o0200, 12'o1010);  // add 7777
    load(12'o0201, 12'o1011);  // add 1 -> carry, R6
    load(12'o0202, 12'o1010);
    load(12'o0203, 12'o0014);  // AND, R5
    load(12'o0204, 12'o3015);  // deposit, R7
    load(12'o0205, 12'o2012);  // increment 7777 -> skip, R8
    load(12'o0206, 12'o7000);  // skipped
    load(12'o0207, 12'o1413);  // indirect add, R4
    load(12'o0210, 12'o7200);  // clear acc, R11
    load(12'o0211, 12'o1260);  // current-page add, R3
    load(12'o0212, 12'o4020);  // subroutine jump, R10
    load(12'o0021, 12'o5420);  // indirect return jump, R9
    load(12'o0213, 12'o6000);  // I/O no-op, R11
    load(12'o0214, 12'o5214);  // jump to self
    run(16, "directed");

    // directed: PC wrap at the top of memory, R12
    load(12'o0200, 12'o5416); load(12'o0016, 12'o7777);
    load(12'o7777, 12'o1011); load(12'o0000, 12'o5000);
    run(5, "wrap");

    // constrained random memory image
    for (int a = 0; a < 4096; a++) load(12'(a), 12'($urandom));
    run(3000, "random");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule